// File: doc/BRIEF.md
# Two-Rank Weighted Bit Counter

This block is a purely combinational generalized parallel counter. It takes bits from two neighbouring columns of a partial-product or multi-operand array: K0 bits that carry weight 1 and K1 bits that carry weight 2. It returns their weighted total, the number of set weight-1 bits plus twice the number of set weight-2 bits, as an N-bit unsigned value. In a compressor tree, many copies of it reduce tall columns of dots in a few logic levels before a final carry-propagate adder.

A configuration is written (K1, K0; N), listing the higher column first and the output width last. The configurations (0,6;3) and (0,5;3) are built as a fixed structure. A 3:2 full adder takes three weight-1 bits and a 2:2 half adder takes two more. A two-bit ripple adder then sums the two sum/carry pairs, with the remaining weight-1 bit entering as its carry-in. For (0,5;3), the half adder's second input is tied low. Every other legal configuration, such as (3,3;4), (3,4;4) or (3,5;4), uses a generic weighted-count path. A plain m:n counter is the case K1 = 0. A configuration whose N cannot hold 2*K1 + K0 stops elaboration with an error.

Top module: `gpc_two_col`

## Requirements
- R1: `count_o` equals the number of set bits in `bits_w1` plus twice the number of set bits in `bits_w2[K1-1:0]`, as an unsigned N-bit value, and it settles in the same cycle as the inputs with no clock.
- R2: In the default (0,6;3) configuration, `bits_w1[0]` is the ripple adder's carry-in, bits 1..3 feed the full adder and bits 4..5 feed the half adder. The three output bits give the weighted count, so a single set bit at any index yields 1.
- R3: `count_o` never exceeds 2*K1 + K0. With every counted input set, it equals exactly that maximum (6 for the default).
- R4: The full adder returns, as {carry, sum}, the count of its three equal-weight inputs (three set bits among indices 1..3 give 3).
- R5: The half adder returns, as {carry, sum}, the count of its two equal-weight inputs (indices 4 and 5 both set give 2).
- R6: The ripple adder returns a + b + carry-in as {cout, sum}, so the carry-in bit adds exactly 1 to any pattern of the other five inputs.
- R7: When K1 = 0, `bits_w2` is one bit wide and has no effect on `count_o`.
- R8: The configurations (0,5;3), (3,3;4), (3,4;4) and (3,5;4) each give the R1 weighted count for every input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_w1 | input | max(K0,1) | Bits of weight 1 (lower column) |
| bits_w2 | input | max(K1,1) | Bits of weight 2 (upper column); unused when K1 = 0 |
| count_o | output | N | Weighted count of the set input bits |

## Verification
The embedded checks rely on every input bit being a known 0 or 1. They skip their comparison while any input is unknown, and the stimulus only ever drives clean binary values. They also take the upper column as inert when it holds no counted bits. The stimulus therefore toggles that one-bit port in the zero-K1 instances and compares against a reference that ignores it. Because each configuration has at most nine inputs, the stimulus sweeps the full input space of every instance, so no pattern is left to the assertions alone.

// File: rtl/gpc_pkg.sv
// Package: shared helpers for the two-rank weighted bit counter.
// Assumes: counts are small (a few tens of bits at most).
package gpc_pkg;

    // Width of a port that must exist even when it carries no counted bits.
    function automatic int unsigned port_w(input int unsigned count);
        return (count > 0) ? count : 1;
    endfunction

    // Largest weighted total a (k1, k0) counter can produce.
    function automatic int unsigned max_sum(input int unsigned k1, input int unsigned k0);
        return 2 * k1 + k0;
    endfunction

    // Output bits required to represent 0 .. max_sum inclusive.
    function automatic int unsigned min_out_w(input int unsigned k1, input int unsigned k0);
        return $clog2(max_sum(k1, k0) + 1);
    endfunction

endpackage

// File: rtl/gpc_full_add.sv
// Module: 3:2 counter. Counts three bits of equal weight and returns the
// total as {carry_o, sum_o}.
// Assumes: inputs are known 0/1 values when the check is evaluated.
module gpc_full_add (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic sum_o,
    output logic carry_o
);

    // Parity and majority of the three inputs.
    always_comb begin
        sum_o   = x_i ^ y_i ^ z_i;
        carry_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    end

    // R4: the two outputs read as a binary count of the inputs.
    always_comb begin
        if (!$isunknown({x_i, y_i, z_i})) begin
            a_r4_fa_count: assert ({carry_o, sum_o} == 2'(x_i) + 2'(y_i) + 2'(z_i))
                else $error("full adder count mismatch");
        end
    end

endmodule

// File: rtl/gpc_half_add.sv
// Module: 2:2 counter. Counts two bits of equal weight and returns the
// total as {carry_o, sum_o}.
// Assumes: inputs are known 0/1 values when the check is evaluated.
module gpc_half_add (
    input  logic x_i,
    input  logic y_i,
    output logic sum_o,
    output logic carry_o
);

    // Parity and conjunction of the two inputs.
    always_comb begin
        sum_o   = x_i ^ y_i;
        carry_o = x_i & y_i;
    end

    // R5: the two outputs read as a binary count of the inputs.
    always_comb begin
        if (!$isunknown({x_i, y_i})) begin
            a_r5_ha_count: assert ({carry_o, sum_o} == 2'(x_i) + 2'(y_i))
                else $error("half adder count mismatch");
        end
    end

endmodule

// File: rtl/gpc_ripple_add.sv
// Module: W-bit ripple-carry adder built from 3:2 counters. Bit 0's
// counter takes cin_i, so a spare weight-1 bit can be absorbed for free.
// Assumes: W >= 1; inputs are known when the check is evaluated.
module gpc_ripple_add #(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] carry;

    // Carry chain entry point.
    assign carry[0] = cin_i;

    // One full adder per bit position, carry passed upward.
    for (genvar i = 0; i < W; i++) begin : g_bit
        gpc_full_add u_fa (
            .x_i     (a_i[i]),
            .y_i     (b_i[i]),
            .z_i     (carry[i]),
            .sum_o   (sum_o[i]),
            .carry_o (carry[i+1])
        );
    end

    assign cout_o = carry[W];

    // R6: chain output equals the arithmetic sum of both operands and carry-in.
    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            a_r6_ripple_sum: assert ({cout_o, sum_o} == (W+1)'(a_i) + (W+1)'(b_i) + (W+1)'(cin_i))
                else $error("ripple adder sum mismatch");
        end
    end

endmodule

// File: rtl/gpc_two_col.sv
// Module: two-rank generalized parallel counter (K1, K0; N).
// Counts K0 weight-1 bits and K1 weight-2 bits and returns the weighted
// total on N bits, combinationally. (0,6;3) and (0,5;3) use a full adder,
// a half adder and a two-bit ripple adder with bits_w1[0] as carry-in;
// other configurations use a generic weighted count.
// Assumes: N is wide enough for 2*K1 + K0 (checked at elaboration);
// bits_w2 is ignored when K1 = 0.
module gpc_two_col
    import gpc_pkg::*;
#(
    parameter int unsigned K1 = 0,
    parameter int unsigned K0 = 6,
    parameter int unsigned N  = 3
) (
    input  logic [port_w(K0)-1:0] bits_w1,
    input  logic [port_w(K1)-1:0] bits_w2,
    output logic [N-1:0]          count_o
);

    localparam int unsigned MAX_SUM    = max_sum(K1, K0);
    localparam int unsigned MIN_N      = min_out_w(K1, K0);
    localparam bit          STRUCTURED = (K1 == 0) && (K0 == 6 || K0 == 5) && (N == 3);

    // Reject configurations whose output cannot hold the largest count.
    if (N < MIN_N) begin : g_bad_cfg
        $error("gpc_two_col: N=%0d too narrow for (%0d,%0d), need %0d", N, K1, K0, MIN_N);
    end

    if (STRUCTURED) begin : g_fa_ha
        logic [5:0] lane;
        logic       fa_s, fa_c, ha_s, ha_c;
        logic [1:0] low_sum;
        logic       top_bit;

        // Pad the five-input variant with a constant zero in lane 5.
        always_comb begin
            lane = '0;
            lane[K0-1:0] = bits_w1[K0-1:0];
        end

        gpc_full_add u_fa (
            .x_i     (lane[1]),
            .y_i     (lane[2]),
            .z_i     (lane[3]),
            .sum_o   (fa_s),
            .carry_o (fa_c)
        );

        gpc_half_add u_ha (
            .x_i     (lane[4]),
            .y_i     (lane[5]),
            .sum_o   (ha_s),
            .carry_o (ha_c)
        );

        // Sums at rank 0, carries at rank 1, lane 0 enters as carry-in.
        gpc_ripple_add #(.W(2)) u_cpa (
            .a_i    ({fa_c, fa_s}),
            .b_i    ({ha_c, ha_s}),
            .cin_i  (lane[0]),
            .sum_o  (low_sum),
            .cout_o (top_bit)
        );

        assign count_o = {top_bit, low_sum};
    end else begin : g_generic
        // Accumulate unit weights for the lower column, double for the upper.
        always_comb begin
            int unsigned acc;
            acc = 0;
            for (int unsigned i = 0; i < K0; i++) acc += 32'(bits_w1[i]);
            for (int unsigned j = 0; j < K1; j++) acc += 32'(bits_w2[j]) << 1;
            count_o = N'(acc);
        end
    end

    // R1, R3: output matches the weighted population count and stays in range.
    always_comb begin
        int unsigned ones_lo, ones_hi;
        ones_lo = (K0 > 0) ? 32'($countones(bits_w1)) : 0;
        ones_hi = (K1 > 0) ? 32'($countones(bits_w2)) : 0;
        if (!$isunknown({bits_w1, bits_w2})) begin
            a_r1_weighted_sum: assert (32'(count_o) == ones_lo + 2 * ones_hi)
                else $error("weighted count mismatch");
            a_r3_no_overflow: assert (32'(count_o) <= MAX_SUM)
                else $error("count above configured maximum");
        end
    end

endmodule

// File: tb/gpc_two_col_tb.sv
// Bench: directed table for the default (0,6;3) counter, then exhaustive
// sweeps of every instance against a bench-side weighted popcount.
module gpc_two_col_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Default (0,6;3)
    logic [5:0] d_lo;  logic d_hi;  logic [2:0] d_out;
    // (0,5;3)
    logic [4:0] a_lo;  logic a_hi;  logic [2:0] a_out;
    // (3,3;4)
    logic [2:0] b_lo;  logic [2:0] b_hi;  logic [3:0] b_out;
    // (3,4;4)
    logic [3:0] c_lo;  logic [2:0] c_hi;  logic [3:0] c_out;
    // (3,5;4)
    logic [4:0] e_lo;  logic [2:0] e_hi;  logic [3:0] e_out;

    gpc_two_col u_dut (.bits_w1(d_lo), .bits_w2(d_hi), .count_o(d_out));
    gpc_two_col #(.K1(0), .K0(5), .N(3)) u_c053 (.bits_w1(a_lo), .bits_w2(a_hi), .count_o(a_out));
    gpc_two_col #(.K1(3), .K0(3), .N(4)) u_c334 (.bits_w1(b_lo), .bits_w2(b_hi), .count_o(b_out));
    gpc_two_col #(.K1(3), .K0(4), .N(4)) u_c344 (.bits_w1(c_lo), .bits_w2(c_hi), .count_o(c_out));
    gpc_two_col #(.K1(3), .K0(5), .N(4)) u_c354 (.bits_w1(e_lo), .bits_w2(e_hi), .count_o(e_out));

    // Directed vectors for (0,6;3): {input[5:0], expected[2:0]}.
    localparam logic [8:0] VEC [12] = '{
        {6'b000000, 3'd0},  // R1 all clear
        {6'b000001, 3'd1},  // R6 carry-in alone
        {6'b000010, 3'd1},  // R2 single full-adder input
        {6'b001110, 3'd3},  // R4 full adder saturated
        {6'b110000, 3'd2},  // R5 half adder saturated
        {6'b110001, 3'd3},  // R6 carry-in on half adder
        {6'b001111, 3'd4},  // R6 carry-in on full adder
        {6'b111110, 3'd5},  // R2 everything but carry-in
        {6'b111111, 3'd6},  // R3 maximum
        {6'b101010, 3'd3},  // R2 alternating
        {6'b010101, 3'd3},  // R2 alternating
        {6'b100001, 3'd2}   // R2 ends only
    };

    function automatic int ref_count(input int lo, input int hi, input int k0, input int k1);
        int s = 0;
        for (int i = 0; i < k0; i++) s += (lo >> i) & 1;
        for (int j = 0; j < k1; j++) s += 2 * ((hi >> j) & 1);
        return s;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        d_lo = '0; d_hi = '0; a_lo = '0; a_hi = '0;
        b_lo = '0; b_hi = '0; c_lo = '0; c_hi = '0; e_lo = '0; e_hi = '0;
        @(negedge clk);
        // R1: quiescent inputs give a zero count on every instance.
        check("R1 idle default", int'(d_out), 0);
        check("R1 idle (3,5;4)", int'(e_out), 0);

        // Directed table walk.
        for (int v = 0; v < 12; v++) begin
            @(posedge clk);
            d_lo = VEC[v][8:3];
            @(negedge clk);
            check($sformatf("R2 vector %0d", v), int'(d_out), int'(VEC[v][2:0]));
        end

        // R1/R7: default exhaustive, upper port toggled and ignored.
        for (int p = 0; p < 128; p++) begin
            @(posedge clk);
            d_lo = 6'(p); d_hi = p[6];
            @(negedge clk);
            check("R7 default sweep", int'(d_out), ref_count(p & 63, 0, 6, 0));
        end

        // R6: carry-in bit adds exactly one to any other pattern.
        for (int p = 0; p < 32; p++) begin
            @(posedge clk);
            d_lo = {5'(p), 1'b1}; d_hi = 1'b0;
            @(negedge clk);
            check("R6 carry-in adds one", int'(d_out), ref_count(p, 0, 5, 0) + 1);
        end

        // R8/R7: (0,5;3) exhaustive with upper port toggled.
        for (int p = 0; p < 64; p++) begin
            @(posedge clk);
            a_lo = 5'(p); a_hi = p[5];
            @(negedge clk);
            check("R8 (0,5;3)", int'(a_out), ref_count(p & 31, 0, 5, 0));
        end

        // R8: (3,3;4) exhaustive.
        for (int p = 0; p < 64; p++) begin
            @(posedge clk);
            b_lo = 3'(p); b_hi = 3'(p >> 3);
            @(negedge clk);
            check("R8 (3,3;4)", int'(b_out), ref_count(p & 7, p >> 3, 3, 3));
        end

        // R8: (3,4;4) exhaustive.
        for (int p = 0; p < 128; p++) begin
            @(posedge clk);
            c_lo = 4'(p); c_hi = 3'(p >> 4);
            @(negedge clk);
            check("R8 (3,4;4)", int'(c_out), ref_count(p & 15, p >> 4, 4, 3));
        end

        // R8/R3: (3,5;4) exhaustive, includes the maximum of 11.
        for (int p = 0; p < 256; p++) begin
            @(posedge clk);
            e_lo = 5'(p); e_hi = 3'(p >> 5);
            @(negedge clk);
            check("R8 (3,5;4)", int'(e_out), ref_count(p & 31, p >> 5, 5, 3));
        end

        @(posedge clk);
        e_lo = '1; e_hi = '1;
        @(negedge clk);
        check("R3 (3,5;4) maximum", int'(e_out), 11);

        finish_run();
    end

    // Watchdog: a hung run counts as one failure and still summarises.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule